// File: doc/BRIEF.md
# Two-Channel Double-Buffered Converter Code Front End

This block is the digital side of a two-channel, 12-bit digital-to-analog converter. A host writes codes over a parallel bus that is either 12 bits or 8 bits wide. Each channel keeps two tiers of storage. The first tier is an input register that the host writes. The second tier is a converter register that feeds the analog ladder. The host can fill both input registers one at a time and then move both codes into the converter registers with a single strobe, so both outputs change together.

The bus controls are active-low and level-sensitive. They are modelled as enables that the clock samples on every edge. When an enable is held active, the register follows its source, one cycle later for each tier. A small controller state machine sets the mode of the second tier. In ST_HOLD the converter registers keep their codes. In ST_FOLLOW they reload from the input registers. In ST_FORCE_MID they are forced to midscale. On every clock the controller moves to ST_FORCE_MID when clear and write 2 are both low. Otherwise it moves to ST_FOLLOW when transfer and write 2 are both low, and to ST_HOLD in all other cases. Any state can move to any of the three.

Each channel presents its held code in segmented form. The top three bits are decoded into seven equally weighted thermometer lines, and the low nine bits are passed through in binary.

Top module: `dual_dac_front`

## Requirements
- R1: While `rst_n` is low, both input registers and both converter registers are set to 12'h800. After reset every channel shows thermometer 7'b0001111 and binary 9'h000, and a transfer with no write before it leaves these values in place.
- R2: An input register is written on a clock edge only when `cs_n` and `wr1_n` are both low at that edge. `addr`=0 selects channel 1 and `addr`=1 selects channel 2. The channel that is not addressed keeps its input register, and with either line high no input register changes.
- R3: When `wide_mode`=1, the addressed input register takes all 12 bits of `bus_d` unchanged.
- R4: When `wide_mode`=0, the addressed input register takes `bus_d[11:8]` into its bits 3..0 and keeps its bits 11..4. An 8-bit host therefore writes the high byte in wide mode and the low nibble in byte mode.
- R5: If `wr2_n` and `xfer_n` are both low at edge k, both converter registers load their input registers at edge k+1. With no transfer or clear, the converter registers hold their codes, even when the input registers are written.
- R6: If `wr2_n` and `clr_n` are both low at edge k, both converter registers become 12'h800 at edge k+1. This wins over a transfer at the same time, and the value stays after clear is released as long as no transfer follows.
- R7: With `wr2_n` and `xfer_n` held low, a clear pulse shows midscale only while it lasts. One edge after clear is sampled high, the earlier codes appear again.
- R8: With `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` all held low in wide mode, a code on the bus appears on the addressed channel two edges later. The other channel keeps its code. With only `cs_n` and `wr1_n` held low, a transfer strobe moves the current bus code to the output.
- R9: Thermometer bit i of a channel is 1 exactly when code[11:9] > i, for i = 0..6. The binary output is code[8:0]. Channel 1 uses `therm_o[6:0]` and `bin_o[8:0]`, and channel 2 uses `therm_o[13:7]` and `bin_o[17:9]`.
- R10: `wr2_n` low with both `xfer_n` and `clr_n` high puts the controller in ST_HOLD, and the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on preset) |
| bus_d | input | 12 | Host data bus |
| addr | input | 1 | Channel address: 0 selects channel 1, 1 selects channel 2 |
| wide_mode | input | 1 | 1 selects 12-bit writes, 0 selects low-nibble byte writes |
| cs_n | input | 1 | Chip select, active low |
| wr1_n | input | 1 | Input-register write strobe, active low |
| wr2_n | input | 1 | Second-tier strobe, active low |
| xfer_n | input | 1 | Transfer request, active low |
| clr_n | input | 1 | Clear request, active low |
| therm_o | output | 14 | Thermometer lines, 7 per channel |
| bin_o | output | 18 | Binary low bits, 9 per channel |

## Verification
The main sweep writes all eight values of the top three bits, with varied low bits, into the two channels. Channel 2 gets the mirror of channel 1, which shows whether each thermometer level decodes correctly, whether the two channels are addressed apart and whether a transfer moves both at once. Further patterns:
- Writes with the strobes partly inactive, and writes without a transfer, show that the first tier is gated and that the second tier holds.
- Two-step byte loads show the nibble routing and that the high byte is kept.
- Clear used on its own, clear together with a held transfer, and clear after a held transfer is released show that clear has priority, that midscale stays, and that codes come back after a temporary hold.
- Held strobe combinations compare the fully transparent path with the semi-transparent path.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;
    typedef enum logic [1:0] {
        ST_HOLD      = 2'd0,
        ST_FOLLOW    = 2'd1,
        ST_FORCE_MID = 2'd2
    } tier_state_e;
endpackage

// File: rtl/dac_tier_ctrl.sv
module dac_tier_ctrl
    import dac_fe_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr2_n,
    input  logic xfer_n,
    input  logic clr_n,
    output logic load_en,
    output logic mid_en
);
    tier_state_e state_q, state_d;

    // Next state from the sampled level controls; clear outranks transfer
    always_comb begin
        if (!wr2_n && !clr_n)
            state_d = ST_FORCE_MID;
        else if (!wr2_n && !xfer_n)
            state_d = ST_FOLLOW;
        else
            state_d = ST_HOLD;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_HOLD;
        else        state_q <= state_d;
    end

    always_comb begin
        load_en = 1'b0;
        mid_en  = 1'b0;
        unique case (state_q)
            ST_HOLD:      ;
            ST_FOLLOW:    load_en = 1'b1;
            ST_FORCE_MID: mid_en  = 1'b1;
            default:      ;
        endcase
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr2_n && !clr_n && !xfer_n) |=> (mid_en && !load_en)); // R6
endmodule

// File: rtl/dac_seg_decode.sv
module dac_seg_decode #(
    parameter int DW  = 12,
    parameter int SEG = 3
) (
    input  logic [DW-1:0]       code,
    output logic [(1<<SEG)-2:0] therm,
    output logic [DW-SEG-1:0]   bin
);
    localparam int THERM_W = (1 << SEG) - 1;

    for (genvar i = 0; i < THERM_W; i++) begin : g_level
        assign therm[i] = (code[DW-1 -: SEG] > SEG'(i));
    end

    assign bin = code[DW-SEG-1:0];
endmodule

// File: rtl/dac_channel.sv
module dac_channel #(
    parameter int DW     = 12,
    parameter int BYTE_W = 8,
    parameter int SEG    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                wide,
    input  logic [DW-1:0]       bus,
    input  logic                load_en,
    input  logic                mid_en,
    output logic [(1<<SEG)-2:0] therm,
    output logic [DW-SEG-1:0]   bin
);
    localparam int NIB_W = DW - BYTE_W;
    localparam logic [DW-1:0] MID = {1'b1, {(DW-1){1'b0}}};

    logic [DW-1:0] in_q, dac_q;

    // First tier: input register, byte mode routes the top lines into the low nibble
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            in_q <= MID;
        end else if (wr_en) begin
            if (wide) in_q <= bus;
            else      in_q[NIB_W-1:0] <= bus[DW-1 -: NIB_W];
        end
    end

    // Second tier: converter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       dac_q <= MID;
        else if (mid_en)  dac_q <= MID;
        else if (load_en) dac_q <= in_q;
    end

    dac_seg_decode #(.DW(DW), .SEG(SEG)) i_dec (
        .code (dac_q),
        .therm(therm),
        .bin  (bin)
    );

    AST_INREG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(in_q)); // R2
    AST_BYTE_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wide) |=> (in_q[DW-1:NIB_W] == $past(in_q[DW-1:NIB_W]))); // R4
    AST_DAC_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !mid_en) |=> (dac_q == $past(in_q))); // R5
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !mid_en) |=> $stable(dac_q)); // R5
    AST_DAC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mid_en |=> (dac_q == MID)); // R6
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front #(
    parameter int DW     = 12,
    parameter int BYTE_W = 8,
    parameter int SEG    = 3,
    parameter int NCH    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [DW-1:0]                 bus_d,
    input  logic [$clog2(NCH)-1:0]        addr,
    input  logic                          wide_mode,
    input  logic                          cs_n,
    input  logic                          wr1_n,
    input  logic                          wr2_n,
    input  logic                          xfer_n,
    input  logic                          clr_n,
    output logic [NCH*((1<<SEG)-1)-1:0]   therm_o,
    output logic [NCH*(DW-SEG)-1:0]       bin_o
);
    localparam int ADDR_W  = $clog2(NCH);
    localparam int THERM_W = (1 << SEG) - 1;
    localparam int BIN_W   = DW - SEG;

    logic load_en, mid_en;
    logic [NCH-1:0] wr_en;

    dac_tier_ctrl i_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr2_n  (wr2_n),
        .xfer_n (xfer_n),
        .clr_n  (clr_n),
        .load_en(load_en),
        .mid_en (mid_en)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign wr_en[c] = !cs_n && !wr1_n && (addr == ADDR_W'(c));

        dac_channel #(.DW(DW), .BYTE_W(BYTE_W), .SEG(SEG)) i_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en[c]),
            .wide   (wide_mode),
            .bus    (bus_d),
            .load_en(load_en),
            .mid_en (mid_en),
            .therm  (therm_o[c*THERM_W +: THERM_W]),
            .bin    (bin_o[c*BIN_W +: BIN_W])
        );
    end

    AST_ONE_WRITER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_en)); // R2
endmodule

// File: tb/test_dual_dac_front.sv
module test_dual_dac_front;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] bus_d;
    logic [0:0]  addr;
    logic        wide_mode, cs_n, wr1_n, wr2_n, xfer_n, clr_n;
    logic [13:0] therm_o;
    logic [17:0] bin_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dual_dac_front i_dual_dac_front (
        .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .addr(addr),
        .wide_mode(wide_mode), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
        .xfer_n(xfer_n), .clr_n(clr_n), .therm_o(therm_o), .bin_o(bin_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    function automatic logic [6:0] exp_therm(logic [11:0] code);
        logic [6:0] t;
        for (int i = 0; i < 7; i++) t[i] = (int'(code[11:9]) > i);
        return t;
    endfunction

    task automatic chk(int ch, logic [11:0] code, string tag);
        logic [6:0] at;
        logic [8:0] ab;
        at = therm_o[ch*7 +: 7];
        ab = bin_o[ch*9 +: 9];
        checks++;
        if (at !== exp_therm(code) || ab !== code[8:0]) begin
            errors++;
            $display("FAIL %s ch%0d: therm=%b bin=%h expected therm=%b bin=%h",
                     tag, ch + 1, at, ab, exp_therm(code), code[8:0]);
        end
    endtask

    task automatic wr_in(logic a, logic [11:0] d, logic w);
        addr = a; bus_d = d; wide_mode = w;
        cs_n = 0; wr1_n = 0;
        tick();
        cs_n = 1; wr1_n = 1; wide_mode = 1;
    endtask

    task automatic xfer_pulse();
        wr2_n = 0; xfer_n = 0;
        tick();
        wr2_n = 1; xfer_n = 1;
        tick();
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        rst_n = 0; bus_d = '0; addr = '0; wide_mode = 1;
        cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; clr_n = 1;
        repeat (3) tick();
        rst_n = 1;
        tick();

        // R1: reset state and preset input registers
        chk(0, 12'h800, "R1 reset");
        chk(1, 12'h800, "R1 reset");
        xfer_pulse();
        chk(0, 12'h800, "R1 input preset");
        chk(1, 12'h800, "R1 input preset");

        // R2 R3 R5 R9: sweep all top-bit levels on both channels
        for (int t = 0; t < 8; t++) begin
            logic [11:0] c1, c2;
            c1 = {3'(t), 9'(t * 37 + 5)};
            c2 = {3'(7 - t), 9'(511 - t * 61)};
            wr_in(0, c1, 1);
            wr_in(1, c2, 1);
            if (t == 0) begin
                chk(0, 12'h800, "R5 hold before transfer");
                chk(1, 12'h800, "R5 hold before transfer");
            end
            xfer_pulse();
            chk(0, c1, "R9 R3 sweep");
            chk(1, c2, "R2 R5 sweep");
        end

        // R2: write ignored when chip select is high
        wr_in(0, 12'h321, 1);
        wr_in(1, 12'h654, 1);
        xfer_pulse();
        addr = 0; bus_d = 12'h999; cs_n = 1; wr1_n = 0;
        tick();
        wr1_n = 1;
        xfer_pulse();
        chk(0, 12'h321, "R2 cs high ignored");
        chk(1, 12'h654, "R2 other channel");

        // R4: two-step byte load
        wr_in(0, 12'hAB0, 1);
        wr_in(0, 12'hC55, 0);
        xfer_pulse();
        chk(0, 12'hABC, "R4 byte load");
        wr_in(0, 12'h3FF, 0);
        xfer_pulse();
        chk(0, 12'hAB3, "R4 upper kept");

        // R10: write 2 alone holds
        wr_in(1, 12'h0AA, 1);
        wr2_n = 0;
        tick(); tick();
        wr2_n = 1;
        tick();
        chk(1, 12'h654, "R10 wr2 alone");

        // R6: clear on its own, stays after release
        wr2_n = 0; clr_n = 0;
        tick();
        wr2_n = 1; clr_n = 1;
        tick();
        chk(0, 12'h800, "R6 clear");
        chk(1, 12'h800, "R6 clear");
        tick();
        chk(0, 12'h800, "R6 clear held");

        // R7: temporary midscale with transfer held
        wr_in(0, 12'h123, 1);
        wr_in(1, 12'hFED, 1);
        wr2_n = 0; xfer_n = 0;
        tick(); tick();
        chk(0, 12'h123, "R7 follow");
        clr_n = 0;
        tick(); tick();
        chk(0, 12'h800, "R7 R6 clear wins");
        chk(1, 12'h800, "R7 R6 clear wins");
        clr_n = 1;
        tick(); tick();
        chk(0, 12'h123, "R7 restore");
        chk(1, 12'hFED, "R7 restore");
        wr2_n = 1; xfer_n = 1;
        tick();

        // R8: fully transparent
        wide_mode = 1; cs_n = 0; wr1_n = 0; wr2_n = 0; xfer_n = 0;
        addr = 0; bus_d = 12'h5A5;
        tick(); tick();
        chk(0, 12'h5A5, "R8 transparent ch1");
        addr = 1; bus_d = 12'h0F0;
        tick(); tick();
        chk(1, 12'h0F0, "R8 transparent ch2");
        chk(0, 12'h5A5, "R8 other kept");
        wr2_n = 1; xfer_n = 1;
        // R8: semi-transparent
        addr = 0; bus_d = 12'h777;
        tick();
        xfer_pulse();
        cs_n = 1; wr1_n = 1;
        chk(0, 12'h777, "R8 semi-transparent");
        chk(1, 12'h0F0, "R8 semi other");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule